// File: doc/BRIEF.md
# Speculation Register Checkpoint and Rollback Unit

This block holds the architectural general registers of a small processor together with a shadow copy of them. It lets the core open a speculative section, then either keep the work done inside it or undo it. A begin request starts a walk that copies every register into the shadow bank, one register per cycle. The same request also captures the current program counter and status word. While the walk runs, the unit asserts a stall so that the pipeline issues no register writes.

The section can end in two ways. A commit request drops the checkpoint in place and leaves the live registers untouched. A rollback request first spends one cycle setting up. It then walks the shadow bank back into the live registers, one register per cycle. When that walk is done, the unit raises a one-cycle redirect strobe that carries the saved program counter and status, so the fetch logic can resume from the checkpoint.

A begin request that arrives while a checkpoint is already open is dropped, and it sets a sticky nesting-error flag. Commit and rollback requests that arrive with no open checkpoint do nothing.

Top module: `spec_ckpt_unit`

## Requirements
- R1: After reset, all live registers read zero, and stall, spec_active, nest_err and redirect_valid are all low.
- R2: A begin request sampled with stall low and no open checkpoint raises stall from the next cycle for exactly NREG cycles. Once the walk is over, spec_active reads high.
- R3: The checkpoint holds the value of every live register as it stood when the request was accepted. It also holds cur_pc and cur_status as sampled in the request cycle.
- R4: A commit request with a checkpoint open clears spec_active on the next edge, raises no stall and no redirect, and leaves every live register at its current value.
- R5: A rollback request with a checkpoint open raises stall for exactly NREG+1 cycles. After that, every live register holds its checkpointed value.
- R6: In the first cycle after the rollback stall drops, redirect_valid is high for exactly one cycle, and redirect_pc and redirect_status carry the checkpointed program counter and status.
- R7: A begin request while a checkpoint is open raises no stall and leaves the checkpoint unchanged. It sets nest_err, and nest_err then stays high until reset.
- R8: A commit or rollback request with no open checkpoint raises no stall and no redirect, and leaves all live registers unchanged.
- R9: A register write (wr_en high) takes effect at the next edge only when stall is low. Writes presented while stall is high are discarded. rd_data shows the live register at rd_addr combinationally.
- R10: When commit and rollback are requested in the same cycle with a checkpoint open, the rollback is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_begin | input | 1 | Open a speculative section (take a checkpoint) |
| req_commit | input | 1 | Close the section and keep the current state |
| req_rollback | input | 1 | Close the section and return to the checkpoint |
| cur_pc | input | PC_W | Program counter to capture at begin |
| cur_status | input | ST_W | Status word to capture at begin |
| rd_addr | input | $clog2(NREG) | Live register read address |
| rd_data | output | DW | Live register read data |
| wr_en | input | 1 | Live register write enable |
| wr_addr | input | $clog2(NREG) | Live register write address |
| wr_data | input | DW | Live register write data |
| stall | output | 1 | High while a copy or restore walk is running |
| redirect_valid | output | 1 | One-cycle strobe at the end of a rollback |
| redirect_pc | output | PC_W | Checkpointed program counter |
| redirect_status | output | ST_W | Checkpointed status word |
| spec_active | output | 1 | A checkpoint is open |
| nest_err | output | 1 | Sticky flag for a begin request while a checkpoint is open |

## Verification
Every register receives its own round-dependent value, and both endings are used alternately over several rounds. A restore walk that skipped or repeated an index would therefore leave a visibly wrong register, and a commit that touched the bank would show up at once. The stall length is counted edge by edge for both walks, so an off-by-one in the walk counter or a missing setup cycle lengthens or shortens the window. The bench also covers these cases:
- A nested begin is issued with a different program counter. A unit that re-captured it would redirect to the wrong address.
- Writes are held high through a copy walk. A unit that let them through would restore corrupted data.
- Commit and rollback are requested together. A wrong priority would keep the speculative values.
- Commit and rollback are requested with no checkpoint open. A unit that acted on them would stall or redirect spuriously.

// File: rtl/spec_ckpt_pkg.sv
package spec_ckpt_pkg;

    localparam int PC_W = 32;
    localparam int ST_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CKPT     = 2'd1,
        ST_ROLLBACK = 2'd2,
        ST_RESTORE  = 2'd3
    } ckpt_state_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [ST_W-1:0] status;
    } ckpt_ctx_t;

    function automatic logic walk_last(input int unsigned idx, input int unsigned n);
        return idx == (n - 1);
    endfunction

endpackage

// File: rtl/ckpt_regbank.sv
module ckpt_regbank #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int NRD  = 1,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/ckpt_ctx_latch.sv
module ckpt_ctx_latch
    import spec_ckpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  ckpt_ctx_t ctx_in,
    output ckpt_ctx_t ctx_out
);
    always_ff @(posedge clk) begin
        if (rst)          ctx_out <= '0;
        else if (capture) ctx_out <= ctx_in;
    end
endmodule

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
    import spec_ckpt_pkg::*;
#(
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_begin,
    input  logic          req_commit,
    input  logic          req_rollback,
    output ckpt_state_e   state,
    output logic [AW-1:0] walk_idx,
    output logic          copy_we,
    output logic          restore_we,
    output logic          ctx_capture,
    output logic          active,
    output logic          nest_err,
    output logic          redirect_valid
);
    ckpt_state_e   state_n;
    logic [AW-1:0] idx_n;
    logic          active_n;
    logic          last;

    assign last        = walk_last(32'(walk_idx), NREG);
    assign copy_we     = (state == ST_CKPT);
    assign restore_we  = (state == ST_RESTORE);
    assign ctx_capture = (state == ST_IDLE) && !active && req_begin;

    always_comb begin
        state_n  = state;
        idx_n    = walk_idx;
        active_n = active;
        unique case (state)
            ST_IDLE: begin
                if (!active && req_begin) begin
                    state_n = ST_CKPT;
                    idx_n   = '0;
                end else if (active && req_rollback) begin
                    state_n  = ST_ROLLBACK;
                    active_n = 1'b0;
                end else if (active && req_commit) begin
                    active_n = 1'b0;
                end
            end
            ST_CKPT: begin
                idx_n = walk_idx + 1'b1;
                if (last) begin
                    state_n  = ST_IDLE;
                    active_n = 1'b1;
                    idx_n    = '0;
                end
            end
            ST_ROLLBACK: begin
                state_n = ST_RESTORE;
                idx_n   = '0;
            end
            ST_RESTORE: begin
                idx_n = walk_idx + 1'b1;
                if (last) begin
                    state_n = ST_IDLE;
                    idx_n   = '0;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            walk_idx       <= '0;
            active         <= 1'b0;
            nest_err       <= 1'b0;
            redirect_valid <= 1'b0;
        end else begin
            state          <= state_n;
            walk_idx       <= idx_n;
            active         <= active_n;
            redirect_valid <= (state == ST_RESTORE) && last;
            if (req_begin && (active || state == ST_CKPT))
                nest_err <= 1'b1;
        end
    end
endmodule

// File: rtl/spec_ckpt_unit.sv
module spec_ckpt_unit
    import spec_ckpt_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_begin,
    input  logic            req_commit,
    input  logic            req_rollback,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [ST_W-1:0] cur_status,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic            stall,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic [ST_W-1:0] redirect_status,
    output logic            spec_active,
    output logic            nest_err
);
    ckpt_state_e   state;
    logic [AW-1:0] walk_idx;
    logic          copy_we, restore_we, ctx_capture;
    ckpt_ctx_t     ctx_in, ctx_saved;

    logic          live_we;
    logic [AW-1:0] live_waddr;
    logic [DW-1:0] live_wdata;
    logic [AW-1:0] live_raddr [2];
    logic [DW-1:0] live_rdata [2];
    logic [AW-1:0] shad_raddr [1];
    logic [DW-1:0] shad_rdata [1];

    ckpt_ctrl #(.NREG(NREG)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_begin      (req_begin),
        .req_commit     (req_commit),
        .req_rollback   (req_rollback),
        .state          (state),
        .walk_idx       (walk_idx),
        .copy_we        (copy_we),
        .restore_we     (restore_we),
        .ctx_capture    (ctx_capture),
        .active         (spec_active),
        .nest_err       (nest_err),
        .redirect_valid (redirect_valid)
    );

    assign stall = (state != ST_IDLE);

    assign live_we    = restore_we || (wr_en && !stall);
    assign live_waddr = restore_we ? walk_idx      : wr_addr;
    assign live_wdata = restore_we ? shad_rdata[0] : wr_data;
    assign live_raddr[0] = rd_addr;
    assign live_raddr[1] = walk_idx;
    assign shad_raddr[0] = walk_idx;
    assign rd_data = live_rdata[0];

    ckpt_regbank #(.NREG(NREG), .DW(DW), .NRD(2)) u_live (
        .clk   (clk),
        .rst   (rst),
        .we    (live_we),
        .waddr (live_waddr),
        .wdata (live_wdata),
        .raddr (live_raddr),
        .rdata (live_rdata)
    );

    ckpt_regbank #(.NREG(NREG), .DW(DW), .NRD(1)) u_shadow (
        .clk   (clk),
        .rst   (rst),
        .we    (copy_we),
        .waddr (walk_idx),
        .wdata (live_rdata[1]),
        .raddr (shad_raddr),
        .rdata (shad_rdata)
    );

    assign ctx_in.pc     = cur_pc;
    assign ctx_in.status = cur_status;

    ckpt_ctx_latch u_ctx (
        .clk     (clk),
        .rst     (rst),
        .capture (ctx_capture),
        .ctx_in  (ctx_in),
        .ctx_out (ctx_saved)
    );

    assign redirect_pc     = ctx_saved.pc;
    assign redirect_status = ctx_saved.status;
endmodule

// File: rtl/spec_ckpt_chk.sv
module spec_ckpt_chk (
    input logic clk,
    input logic rst,
    input logic req_begin,
    input logic req_commit,
    input logic req_rollback,
    input logic stall,
    input logic redirect_valid,
    input logic spec_active,
    input logic nest_err
);
    // R2: an accepted begin starts the copy walk on the next cycle
    p_begin_stalls_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !spec_active && req_begin) |=> stall);

    // R4: commit of an open checkpoint closes it without a walk
    p_commit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!stall && spec_active && req_commit && !req_rollback) |=> (!stall && !spec_active));

    // R6: the redirect strobe is a single cycle and only outside a walk
    p_redirect_idle_r6: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> !stall);
    p_redirect_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid);

    // R7: the nesting error flag is sticky
    p_nest_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        nest_err |=> nest_err);

    // R7: a nested begin raises no stall
    p_nest_no_walk_r7: assert property (@(posedge clk) disable iff (rst)
        (!stall && spec_active && req_begin && !req_commit && !req_rollback) |=> (!stall && spec_active));

    // R8: close requests with no checkpoint open do nothing
    p_orphan_close_r8: assert property (@(posedge clk) disable iff (rst)
        (!stall && !spec_active && !req_begin && (req_commit || req_rollback))
        |=> (!stall && !spec_active && !redirect_valid));

    // R10: rollback wins over commit
    p_rollback_prio_r10: assert property (@(posedge clk) disable iff (rst)
        (!stall && spec_active && req_rollback) |=> stall);
endmodule

bind spec_ckpt_unit spec_ckpt_chk u_chk (.*);

// File: tb/spec_ckpt_unit_bench.sv
`timescale 1ns/1ps
module spec_ckpt_unit_bench;
    localparam int NREG = 8;
    localparam int DW   = 32;
    localparam int AW   = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst;
    logic            req_begin, req_commit, req_rollback;
    logic [31:0]     cur_pc;
    logic [7:0]      cur_status;
    logic [AW-1:0]   rd_addr;
    logic [DW-1:0]   rd_data;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;
    logic            stall, redirect_valid, spec_active, nest_err;
    logic [31:0]     redirect_pc;
    logic [7:0]      redirect_status;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spec_ckpt_unit #(.NREG(NREG), .DW(DW)) u_spec_ckpt_unit (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] val_pre(input int r, input int i);
        return 32'hA5000000 ^ (r << 16) ^ (i * 32'h0000_0123) ^ 32'h5;
    endfunction

    function automatic logic [DW-1:0] val_spec(input int r, input int i);
        return ~val_pre(r, i) + (i << 4);
    endfunction

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic check_regs(input string req, input int r, input bit pre);
        for (int i = 0; i < NREG; i++) begin
            rd_addr = AW'(i);
            #0.1;
            chk(req, 64'(rd_data), 64'(pre ? val_pre(r, i) : val_spec(r, i)));
        end
    endtask

    // Applies one request pulse; returns number of stalled cycles afterwards.
    task automatic pulse(input bit b, input bit c, input bit rb, input bit junk_wr, output int cyc);
        req_begin = b; req_commit = c; req_rollback = rb;
        step();
        req_begin = 0; req_commit = 0; req_rollback = 0;
        if (junk_wr) begin wr_en = 1'b1; wr_addr = AW'(3); wr_data = 32'hDEAD_BEEF; end
        cyc = 0;
        while (stall && cyc < 1000) begin
            cyc++;
            step();
        end
        wr_en = 1'b0;
    endtask

    initial begin
        int cyc;
        logic [31:0] exp_pc;
        logic [7:0]  exp_st;
        rst = 1; req_begin = 0; req_commit = 0; req_rollback = 0;
        cur_pc = 0; cur_status = 0; rd_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1 stall", 64'(stall), 0);
        chk("R1 active", 64'(spec_active), 0);
        chk("R1 nest_err", 64'(nest_err), 0);
        chk("R1 redirect", 64'(redirect_valid), 0);
        for (int i = 0; i < NREG; i++) begin
            rd_addr = AW'(i); #0.1;
            chk("R1 reg zero", 64'(rd_data), 0);
        end

        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < NREG; i++) wr(i, val_pre(r, i));
            // R9 written values visible
            check_regs("R9 write", r, 1);
            // R8 orphan closes
            pulse(0, 1, 0, 0, cyc);
            chk("R8 commit no stall", 64'(cyc), 0);
            pulse(0, 0, 1, 0, cyc);
            chk("R8 rollback no stall", 64'(cyc), 0);
            chk("R8 no redirect", 64'(redirect_valid), 0);
            check_regs("R8 regs kept", r, 1);

            exp_pc = 32'h0000_1000 + r * 32'h40;
            exp_st = 8'(r + 5);
            cur_pc = exp_pc; cur_status = exp_st;
            pulse(1, 0, 0, r == 0, cyc);
            chk("R2 copy stall length", 64'(cyc), 64'(NREG));
            chk("R2 active", 64'(spec_active), 1);
            // R9 writes during stall discarded
            rd_addr = AW'(3); #0.1;
            chk("R9 stalled write dropped", 64'(rd_data), 64'(val_pre(r, 3)));
            cur_pc = 32'hFFFF_0000; cur_status = 8'hEE;

            for (int i = 0; i < NREG; i++) wr(i, val_spec(r, i));
            check_regs("R9 spec write", r, 0);

            if (r == 1) begin
                pulse(1, 0, 0, 0, cyc);
                chk("R7 nested no stall", 64'(cyc), 0);
                chk("R7 nest_err set", 64'(nest_err), 1);
                chk("R7 still active", 64'(spec_active), 1);
            end

            if (r == 0 || r == 3) begin
                pulse(0, 1, 0, 0, cyc);
                chk("R4 commit no stall", 64'(cyc), 0);
                chk("R4 active cleared", 64'(spec_active), 0);
                chk("R4 no redirect", 64'(redirect_valid), 0);
                check_regs("R4 regs kept", r, 0);
            end else begin
                pulse(0, r == 2, 1, 0, cyc);
                chk(r == 2 ? "R10 rollback stall length" : "R5 rollback stall length",
                    64'(cyc), 64'(NREG + 1));
                chk("R6 redirect strobe", 64'(redirect_valid), 1);
                chk("R3 redirect pc", 64'(redirect_pc), 64'(exp_pc));
                chk("R3 redirect status", 64'(redirect_status), 64'(exp_st));
                chk("R5 active cleared", 64'(spec_active), 0);
                check_regs(r == 2 ? "R10 regs restored" : "R5 regs restored", r, 1);
                step();
                chk("R6 strobe one cycle", 64'(redirect_valid), 0);
            end
            chk("R7 nest_err sticky", 64'(nest_err), r >= 1);
        end

        rst = 1; step(); rst = 0; step();
        chk("R1 nest_err cleared by reset", 64'(nest_err), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule